// File: doc/BRIEF.md
# Register Rename Map with Free Tag List

This block translates architectural register numbers into physical register tags for an out-of-order core. A map table, indexed by architectural register, holds a physical tag and a ready flag for each entry. A circular FIFO holds the physical tags that are not in use. Each rename request carries two source registers and an optional destination. The block returns the current tag and readiness of each source. When the instruction has a destination, it also returns a freshly popped tag for that destination and the tag the destination held before the update. The caller keeps the displaced tag with the instruction and hands it back when the instruction graduates.

Executed results announce their tag on a broadcast port, and every map entry that holds that tag becomes ready. A restore port rewrites one map entry per cycle during misprediction or exception recovery. While the restore port is active, rename is held off. The lookups are combinational from the registered table. The map update, the FIFO pop, the FIFO push and the restore write all take effect at the next rising clock edge.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to tag i with its ready flag set, and the free FIFO holds tags 32 to 63 in that order, so the first destination renames receive 32, 33, 34 and so on.
- R2: Each source output shows the tag currently stored for that source's architectural register, together with that entry's ready flag.
- R3: When a broadcast in the same cycle carries the tag that a source lookup returns, that source's ready output is 1.
- R4: A rename accepted with a destination returns the oldest free tag as the destination tag. From the next cycle, the destination entry holds that tag with its ready flag cleared.
- R5: The previous-tag output is the destination entry's tag before the update. A source naming the same register as the destination also sees the old mapping.
- R6: A broadcast sets the ready flag, from the next cycle, of every map entry holding the broadcast tag. An entry written in the same cycle takes the written value instead.
- R7: A tag presented at graduation is appended to the free FIFO and is handed out after all tags already in it. A tag pushed into an empty FIFO becomes available only in the next cycle.
- R8: Rename-ready is low while the free FIFO is empty and the request has a destination.
- R9: A restore sets the given register's entry to the given tag with its ready flag set. Rename-ready is low in any cycle with an active restore, and the blocked rename has no effect.
- R10: A request without a destination is accepted even when the FIFO is empty, and it changes no map entry and consumes no free tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 1 | Rename request present |
| ren_has_dst | input | 1 | Request writes a destination register |
| ren_src_a | input | 5 | First source architectural register |
| ren_src_b | input | 5 | Second source architectural register |
| ren_dst | input | 5 | Destination architectural register |
| ren_ready | output | 1 | Request is accepted this cycle when valid |
| src_a_tag | output | 6 | Physical tag of the first source |
| src_a_rdy | output | 1 | First source value is available |
| src_b_tag | output | 6 | Physical tag of the second source |
| src_b_rdy | output | 1 | Second source value is available |
| dst_tag | output | 6 | Newly allocated destination tag (head of the free FIFO) |
| prev_tag | output | 6 | Tag the destination held before this rename |
| wb_valid | input | 1 | Result tag broadcast present |
| wb_tag | input | 6 | Broadcast result tag |
| grad_valid | input | 1 | Freed tag present at graduation |
| grad_tag | input | 6 | Tag returned to the free FIFO |
| rb_valid | input | 1 | Recovery restore write present |
| rb_arch | input | 5 | Architectural register to restore |
| rb_tag | input | 6 | Tag to restore into that entry |

## Verification
The assertions assume that graduation never pushes a tag into a full free FIFO. They also assume that the FIFO is popped only through an accepted rename with a destination. The stimulus respects both by returning only tags that a rename earlier displaced, in the order they were displaced. Free plus pending tags therefore never exceed 32. Restore targets and broadcast tags are otherwise unconstrained. Broadcasts are biased toward tags currently in the map so that same-cycle forwarding, multi-entry wakeup and source-equals-destination renames all occur often.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned RN_ARCH_REGS = 32;
  localparam int unsigned RN_PHYS_TAGS = 64;
  localparam int unsigned RN_SRC_PORTS = 2;
endpackage

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned TW         = 6,
  parameter int unsigned INIT_FIRST = 32,
  parameter int unsigned INIT_COUNT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  output logic [TW-1:0] head_tag,
  output logic          empty
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic [TW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign head_tag = mem_q[rd_ptr_q];
  assign empty    = (cnt_q == '0);

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (pop) rd_ptr_d = rd_ptr_q + 1'b1;
    if (push) wr_ptr_d = wr_ptr_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= PW'(INIT_COUNT % DEPTH);
      cnt_q    <= CW'(INIT_COUNT);
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++)
        mem_q[k] <= (k < INIT_COUNT) ? TW'(INIT_FIRST + k) : '0;
    end else if (push) begin
      mem_q[wr_ptr_q] <= push_tag;
    end
  end

  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q < CW'(DEPTH)));
  a_r7_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (push != pop) |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/rename_table.sv
module rename_table #(
  parameter int unsigned NA   = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned TW   = 6,
  parameter int unsigned NSRC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src_arch [NSRC],
  output logic [TW-1:0] src_tag  [NSRC],
  output logic          src_rdy  [NSRC],
  input  logic [AW-1:0] dst_arch,
  output logic [TW-1:0] dst_old_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [TW-1:0] wr_tag,
  input  logic          wr_rdy,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag
);
  logic [TW-1:0] tag_q [NA];
  logic [TW-1:0] tag_d [NA];
  logic [NA-1:0] rdy_q, rdy_d;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_tag[s] = tag_q[src_arch[s]];
    assign src_rdy[s] = rdy_q[src_arch[s]] | (bc_valid && (bc_tag == tag_q[src_arch[s]]));
  end

  assign dst_old_tag = tag_q[dst_arch];

  always_comb begin
    for (int i = 0; i < NA; i++) begin
      tag_d[i] = tag_q[i];
      rdy_d[i] = rdy_q[i];
      if (wr_en && (wr_arch == AW'(i))) begin
        tag_d[i] = wr_tag;
        rdy_d[i] = wr_rdy;
      end else if (bc_valid && (tag_q[i] == bc_tag)) begin
        rdy_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) tag_q[i] <= TW'(i);
      rdy_q <= '1;
    end else begin
      for (int i = 0; i < NA; i++) tag_q[i] <= tag_d[i];
      rdy_q <= rdy_d;
    end
  end

  // R4 (rename) and R9 (restore) share this write port
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tag_q[$past(wr_arch)] == $past(wr_tag)) && (rdy_q[$past(wr_arch)] == $past(wr_rdy)));

  for (genvar i = 0; i < NA; i++) begin : g_chk
    a_r6_bcast_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && (tag_q[i] == bc_tag) && !(wr_en && (wr_arch == AW'(i)))) |=> rdy_q[i]);
  end
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rename_pkg::*;
#(
  parameter int unsigned ARCH_REGS = RN_ARCH_REGS,
  parameter int unsigned PHYS_TAGS = RN_PHYS_TAGS,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned TW = $clog2(PHYS_TAGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic          ren_has_dst,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic [TW-1:0] src_a_tag,
  output logic          src_a_rdy,
  output logic [TW-1:0] src_b_tag,
  output logic          src_b_rdy,
  output logic [TW-1:0] dst_tag,
  output logic [TW-1:0] prev_tag,
  input  logic          wb_valid,
  input  logic [TW-1:0] wb_tag,
  input  logic          grad_valid,
  input  logic [TW-1:0] grad_tag,
  input  logic          rb_valid,
  input  logic [AW-1:0] rb_arch,
  input  logic [TW-1:0] rb_tag
);
  localparam int unsigned NSRC = RN_SRC_PORTS;

  logic          fl_empty, alloc, wr_en, wr_rdy;
  logic [TW-1:0] fl_head, wr_tag;
  logic [AW-1:0] wr_arch;
  logic [AW-1:0] s_arch [NSRC];
  logic [TW-1:0] s_tag  [NSRC];
  logic          s_rdy  [NSRC];

  assign s_arch[0] = ren_src_a;
  assign s_arch[1] = ren_src_b;
  assign src_a_tag = s_tag[0];
  assign src_a_rdy = s_rdy[0];
  assign src_b_tag = s_tag[1];
  assign src_b_rdy = s_rdy[1];
  assign dst_tag   = fl_head;

  always_comb begin
    ren_ready = !rb_valid && !(ren_has_dst && fl_empty);
    alloc     = ren_valid && ren_ready && ren_has_dst;
    wr_en     = rb_valid || alloc;
    wr_arch   = rb_valid ? rb_arch : ren_dst;
    wr_tag    = rb_valid ? rb_tag  : fl_head;
    wr_rdy    = rb_valid;
  end

  rename_table #(.NA(ARCH_REGS), .AW(AW), .TW(TW), .NSRC(NSRC)) u_table (
    .clk, .rst_n,
    .src_arch(s_arch), .src_tag(s_tag), .src_rdy(s_rdy),
    .dst_arch(ren_dst), .dst_old_tag(prev_tag),
    .wr_en, .wr_arch, .wr_tag, .wr_rdy,
    .bc_valid(wb_valid), .bc_tag(wb_tag)
  );

  rename_freelist #(.DEPTH(PHYS_TAGS), .TW(TW), .INIT_FIRST(ARCH_REGS),
                    .INIT_COUNT(PHYS_TAGS - ARCH_REGS)) u_free (
    .clk, .rst_n,
    .pop(alloc), .push(grad_valid), .push_tag(grad_tag),
    .head_tag(fl_head), .empty(fl_empty)
  );

  a_r9_restore_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> !ren_ready);
  a_r10_no_dst_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_valid && !ren_has_dst) |-> ren_ready);
  a_r5_prev_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_ready && !wb_valid && !grad_valid && !rb_valid) |=>
      ($past(ren_dst) != ren_dst) || (prev_tag == $past(prev_tag)));
endmodule

// File: tb/rename_map_bench.sv
`timescale 1ns/1ps
module rename_map_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ren_valid, ren_has_dst, ren_ready, src_a_rdy, src_b_rdy;
  logic [4:0] ren_src_a, ren_src_b, ren_dst, rb_arch;
  logic [5:0] src_a_tag, src_b_tag, dst_tag, prev_tag, wb_tag, grad_tag, rb_tag;
  logic wb_valid, grad_valid, rb_valid;

  rename_map u_rename_map (.*);

  int mtag [32];
  bit mrdy [32];
  bit mbc  [32];
  int fq [64];
  int fh, ft, fc;
  int pend [$];
  int n_chk, n_bad;
  bit done;

  function automatic bit exp_rdy(int a);
    return mrdy[a] || (wb_valid && (wb_tag == 6'(mtag[a])));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ren_valid = 0; ren_has_dst = 0; ren_src_a = 0; ren_src_b = 0; ren_dst = 0;
    wb_valid = 0; wb_tag = 0; grad_valid = 0; grad_tag = 0;
    rb_valid = 0; rb_arch = 0; rb_tag = 0;
  endtask

  // compare outputs against the model, then advance the model across the edge
  task automatic step();
    bit e_ready, fire;
    int a, b, d;
    #1;
    a = int'(ren_src_a); b = int'(ren_src_b); d = int'(ren_dst);
    e_ready = !rb_valid && !(ren_has_dst && fc == 0);
    chk(ren_ready == e_ready, rb_valid ? "R9" : (ren_has_dst ? "R8" : "R10"), ren_ready, e_ready);
    fire = ren_valid && e_ready;
    chk(src_a_tag == 6'(mtag[a]), (fire && ren_has_dst && a == d) ? "R5" : "R2", src_a_tag, mtag[a]);
    chk(src_a_rdy == exp_rdy(a),
        (wb_valid && !mrdy[a]) ? "R3" : (mbc[a] ? "R6" : "R2"), src_a_rdy, exp_rdy(a));
    chk(src_b_tag == 6'(mtag[b]), "R2", src_b_tag, mtag[b]);
    chk(src_b_rdy == exp_rdy(b),
        (wb_valid && !mrdy[b]) ? "R3" : (mbc[b] ? "R6" : "R2"), src_b_rdy, exp_rdy(b));
    if (fire && ren_has_dst) begin
      chk(dst_tag == 6'(fq[fh]), "R4", dst_tag, fq[fh]);
      chk(prev_tag == 6'(mtag[d]), "R5", prev_tag, mtag[d]);
    end
    if (wb_valid)
      for (int i = 0; i < 32; i++)
        if (mtag[i] == int'(wb_tag) && !mrdy[i]) begin mrdy[i] = 1; mbc[i] = 1; end
    if (rb_valid) begin
      mtag[rb_arch] = int'(rb_tag); mrdy[rb_arch] = 1; mbc[rb_arch] = 0;
    end else if (fire && ren_has_dst) begin
      pend.push_back(mtag[d]);
      mtag[d] = fq[fh]; mrdy[d] = 0; mbc[d] = 0;
      fh = (fh + 1) % 64; fc--;
    end
    if (grad_valid) begin fq[ft] = int'(grad_tag); ft = (ft + 1) % 64; fc++; end
    @(posedge clk);
  endtask

  task automatic grad_one();
    grad_valid = 1; grad_tag = 6'(pend[0]); void'(pend.pop_front());
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7741);
    idle();
    for (int i = 0; i < 32; i++) begin mtag[i] = i; mrdy[i] = 1; mbc[i] = 0; end
    for (int k = 0; k < 32; k++) fq[k] = 32 + k;
    fh = 0; ft = 32; fc = 32;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset mapping
    for (int a = 0; a < 32; a++) begin
      @(negedge clk); idle(); ren_src_a = 5'(a); ren_src_b = 5'(31 - a);
      #1;
      chk(src_a_tag == 6'(a) && src_a_rdy, "R1", src_a_tag, a);
      chk(src_b_tag == 6'(31 - a) && src_b_rdy, "R1", src_b_tag, 31 - a);
      step();
    end
    // R1/R4: drain the free list in order
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); idle();
      ren_valid = 1; ren_has_dst = 1; ren_dst = 5'(k); ren_src_a = 5'(k);
      #1; chk(dst_tag == 6'(32 + k), "R1", dst_tag, 32 + k);
      step();
    end
    // R4: renamed entry now not ready
    @(negedge clk); idle(); ren_src_a = 5'd7;
    #1; chk(src_a_tag == 6'd39 && !src_a_rdy, "R4", src_a_tag, 39);
    step();
    // R8 stall, R10 no-dst accepted while empty
    @(negedge clk); idle(); ren_valid = 1; ren_has_dst = 1; ren_dst = 5'd3; step();
    @(negedge clk); idle(); ren_valid = 1; ren_has_dst = 0; ren_dst = 5'd3; step();
    // R7: push into empty list is not bypassed
    @(negedge clk); idle(); ren_valid = 1; ren_has_dst = 1; ren_dst = 5'd4; grad_one();
    #1; chk(!ren_ready, "R7", ren_ready, 0);
    step();
    @(negedge clk); idle(); ren_valid = 1; ren_has_dst = 1; ren_dst = 5'd4;
    #1; chk(ren_ready && dst_tag == 6'd0, "R7", dst_tag, 0);
    step();
    // R3: forwarding of a same-cycle broadcast
    @(negedge clk); idle(); ren_src_a = 5'd4; wb_valid = 1; wb_tag = 6'd0;
    #1; chk(src_a_rdy, "R3", src_a_rdy, 1);
    step();
    // R9: restore blocks a rename
    @(negedge clk); idle(); ren_valid = 1; ren_has_dst = 0;
    rb_valid = 1; rb_arch = 5'd9; rb_tag = 6'd41; step();
    @(negedge clk); idle(); ren_src_b = 5'd9;
    #1; chk(src_b_tag == 6'd41 && src_b_rdy, "R9", src_b_tag, 41);
    step();

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); idle();
      ren_valid   = ($urandom % 4) != 0;
      ren_has_dst = ($urandom % 5) != 0;
      ren_dst     = 5'($urandom);
      ren_src_a   = (($urandom % 4) == 0) ? ren_dst : 5'($urandom);
      ren_src_b   = 5'($urandom);
      wb_valid    = ($urandom % 3) == 0;
      wb_tag      = (($urandom % 4) != 0) ? 6'(mtag[$urandom % 32]) : 6'($urandom);
      if (pend.size() > 0 && ($urandom % 8) < 3) grad_one();
      if (($urandom % 20) == 0) begin
        rb_valid = 1; rb_arch = 5'($urandom); rb_tag = 6'($urandom);
      end
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule